// File: doc/BRIEF.md
# APB to Byte-Wide Flash Bridge

This block sits on a 32-bit APB bus as a slave and drives an external flash part that has an 8-bit data bus. Every APB write to the flash window becomes one byte write strobe at the flash pins, carrying the low byte of the write data to the exact byte address. Every APB read from the flash window becomes either a single byte read or a burst of four byte reads, and the bridge packs the bytes into one 32-bit word before returning it. A one-bit mode register, reached at its own APB address, picks which read behaviour is used.

The bridge holds PREADY low for as long as the flash strobes take. Each strobe lasts a fixed number of clocks set by a parameter. Between consecutive strobes of one burst there is one idle clock. An APB access whose address falls outside both the control address and the flash window completes at once with PSLVERR.

Top module: `apb_flash_bridge`

## Requirements
- R1: After reset the chip-enable, output-enable and write-enable pins (all active low) are high. The mode register reads 0, which selects the 32-bit read mode.
- R2: The mode register sits at address CTRL_ADDR. Bit 0 is writable and reads back (0 = 32-bit reads, 1 = single-byte reads). Bits 31:1 always read 0. Accesses to it complete with no wait state.
- R3: An APB write to the flash window produces exactly one write strobe and no read strobe. The strobe drives flash address PADDR[FAW-1:0] and data PWDATA[7:0], and PSLVERR stays low.
- R4: In 32-bit mode a read produces four read strobes at base, base+1, base+2 and base+3, in that order. The bytes are returned little-endian: the byte from base goes to bits 7:0 and the byte from base+3 goes to bits 31:24.
- R5: In single-byte mode a read produces one read strobe at the exact byte address PADDR[FAW-1:0]. The byte is returned in bits 7:0 and bits 31:8 are zero.
- R6: Each flash strobe holds chip-enable together with output-enable or write-enable low for exactly STROBE_CYC clocks. Output-enable and write-enable are never low at the same time. Consecutive strobes of one burst are separated by one clock with all strobes high.
- R7: PREADY stays low until the last strobe ends. This gives 4*STROBE_CYC+4 wait cycles for a 32-bit read, and STROBE_CYC+1 wait cycles for a byte read or a write. PREADY is high for a single cycle per flash access.
- R8: An access outside both the control address and the flash window (flash window: PADDR[AW-1:FAW] equal to FLASH_BASE[AW-1:FAW]) completes with no wait state and PSLVERR high. It causes no flash strobe, leaves the mode register unchanged, and a read returns zero.
- R9: The mode register changes only while no flash transfer is in progress. A control access is held with PREADY low while the sequencer is busy, and each read uses the mode that was set when it started.
- R10: In 32-bit mode the burst base is the APB address with its two low bits cleared, so an unaligned read returns the aligned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error response |
| fl_addr | output | FAW | Flash byte address |
| fl_dout | output | 8 | Byte driven to the flash on writes |
| fl_din | input | 8 | Byte returned by the flash on reads |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
32-bit reads are tried at an aligned and at an unaligned address. A bench flash whose bytes all differ exposes any swapped lane, missing byte or wrong base. Byte reads of a location just written separate the single-strobe path from the burst path and show the upper bits zeroed. A write is counted strobe by strobe, which catches a missing or extra cycle or a read strobe where none belongs. Accesses to unmapped addresses with data that would flip the mode show that an error neither touches the flash nor the register.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_CTRL  = 2'd1,
        HIT_FLASH = 2'd2
    } hit_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_STROBE = 2'd1,
        SQ_GAP    = 2'd2,
        SQ_DONE   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
    } fl_strobe_t;

    localparam logic MODE_WORD = 1'b0;
    localparam logic MODE_BYTE = 1'b1;
    localparam int   LANES     = 4;

    function automatic logic [1:0] burst_last(input logic is_wr, input logic byte_mode);
        return (is_wr || byte_mode) ? 2'd0 : 2'(LANES - 1);
    endfunction

endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
    import fbr_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            FAW        = 12,
    parameter logic [AW-1:0] CTRL_ADDR  = 16'h0100,
    parameter logic [AW-1:0] FLASH_BASE = 16'h8000
) (
    input  logic [AW-1:0] paddr,
    output hit_e          hit
);
    localparam int TAGW = AW - FAW;
    localparam logic [TAGW-1:0] FLASH_TAG = FLASH_BASE[AW-1:FAW];

    always_comb begin
        if (paddr[AW-1:FAW] == FLASH_TAG)
            hit = HIT_FLASH;
        else if (paddr == CTRL_ADDR)
            hit = HIT_CTRL;
        else
            hit = HIT_NONE;
    end
endmodule

// File: rtl/fbr_mode_reg.sv
module fbr_mode_reg
    import fbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_req,
    input  logic wr_bit,
    input  logic busy,
    output logic byte_mode
);
    always_ff @(posedge clk) begin
        if (rst)
            byte_mode <= MODE_WORD;
        else if (wr_req && !busy)
            byte_mode <= wr_bit;
    end

    a_r9_mode_stable_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy ? $stable(byte_mode) : 1'b1));
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
    import fbr_pkg::*;
#(
    parameter int FAW        = 12,
    parameter int STROBE_CYC = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           wr,
    input  logic           byte_mode,
    input  logic [FAW-1:0] addr,
    input  logic [7:0]     wbyte,
    input  logic [7:0]     fl_din,
    output logic [FAW-1:0] fl_addr,
    output logic [7:0]     fl_dout,
    output fl_strobe_t     strobe,
    output logic [31:0]    rdata,
    output logic           busy,
    output logic           done
);
    localparam int CW = $clog2(STROBE_CYC) + 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYC - 1);

    seq_state_e     state;
    logic [CW-1:0]  cnt;
    logic [1:0]     idx;
    logic [1:0]     last_idx;
    logic           is_wr;
    logic           cap;
    logic           clr;

    assign clr = (state == SQ_IDLE) && start;
    assign cap = (state == SQ_STROBE) && (cnt == CNT_LAST) && !is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            idx      <= '0;
            last_idx <= '0;
            is_wr    <= 1'b0;
            fl_addr  <= '0;
            fl_dout  <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    is_wr    <= wr;
                    fl_dout  <= wbyte;
                    fl_addr  <= (wr || byte_mode) ? addr : {addr[FAW-1:2], 2'b00};
                    last_idx <= burst_last(wr, byte_mode);
                    idx      <= '0;
                    cnt      <= '0;
                    state    <= SQ_STROBE;
                end
                SQ_STROBE: begin
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        state <= (idx == last_idx) ? SQ_DONE : SQ_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_GAP: begin
                    idx     <= idx + 1'b1;
                    fl_addr <= fl_addr + 1'b1;
                    state   <= SQ_STROBE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                q <= '0;
            else if (cap && (idx == 2'(g)))
                q <= fl_din;
        end
        assign rdata[g*8 +: 8] = q;
    end

    always_comb begin
        strobe.ce = (state == SQ_STROBE);
        strobe.oe = (state == SQ_STROBE) && !is_wr;
        strobe.we = (state == SQ_STROBE) && is_wr;
    end

    assign busy = (state != SQ_IDLE);
    assign done = (state == SQ_DONE);

    a_r6_oe_we_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(strobe.oe && strobe.we));
    a_r6_strobe_with_ce: assert property (@(posedge clk) disable iff (rst)
        (strobe.oe || strobe.we) |-> strobe.ce);
    a_r6_gap_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_GAP) |=> (state == SQ_STROBE) && $stable(is_wr));
    a_r4_lane_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= last_idx));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/apb_flash_bridge.sv
module apb_flash_bridge
    import fbr_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            FAW        = 12,
    parameter int            STROBE_CYC = 3,
    parameter logic [AW-1:0] CTRL_ADDR  = 16'h0100,
    parameter logic [AW-1:0] FLASH_BASE = 16'h8000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic [AW-1:0]  paddr,
    input  logic [31:0]    pwdata,
    output logic [31:0]    prdata,
    output logic           pready,
    output logic           pslverr,
    output logic [FAW-1:0] fl_addr,
    output logic [7:0]     fl_dout,
    input  logic [7:0]     fl_din,
    output logic           fl_ce_n,
    output logic           fl_oe_n,
    output logic           fl_we_n
);
    hit_e        hit;
    logic        access;
    logic        byte_mode;
    logic        seq_busy;
    logic        seq_done;
    logic        seq_start;
    logic [31:0] seq_rdata;
    fl_strobe_t  strobe;

    assign access = psel && penable;

    fbr_decode #(
        .AW(AW), .FAW(FAW), .CTRL_ADDR(CTRL_ADDR), .FLASH_BASE(FLASH_BASE)
    ) u_decode (
        .paddr (paddr),
        .hit   (hit)
    );

    fbr_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (access && pwrite && (hit == HIT_CTRL)),
        .wr_bit    (pwdata[0]),
        .busy      (seq_busy),
        .byte_mode (byte_mode)
    );

    assign seq_start = access && (hit == HIT_FLASH) && !seq_busy;

    fbr_seq #(
        .FAW(FAW), .STROBE_CYC(STROBE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (seq_start),
        .wr        (pwrite),
        .byte_mode (byte_mode),
        .addr      (paddr[FAW-1:0]),
        .wbyte     (pwdata[7:0]),
        .fl_din    (fl_din),
        .fl_addr   (fl_addr),
        .fl_dout   (fl_dout),
        .strobe    (strobe),
        .rdata     (seq_rdata),
        .busy      (seq_busy),
        .done      (seq_done)
    );

    assign fl_ce_n = !strobe.ce;
    assign fl_oe_n = !strobe.oe;
    assign fl_we_n = !strobe.we;

    always_comb begin
        pready  = 1'b1;
        pslverr = 1'b0;
        prdata  = '0;
        case (hit)
            HIT_FLASH: begin
                pready = seq_done;
                if (seq_done && !pwrite)
                    prdata = seq_rdata;
            end
            HIT_CTRL: begin
                pready = !seq_busy;
                prdata = {31'b0, byte_mode};
            end
            default: pslverr = access;
        endcase
    end

    a_r8_err_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (access && (hit == HIT_NONE)) |-> (fl_ce_n && pready));
    a_r8_err_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (access && (hit == HIT_NONE)) |=> $stable(byte_mode));
    a_r7_flash_wait: assert property (@(posedge clk) disable iff (rst)
        (seq_start) |-> !pready);
endmodule

// File: tb/tb_apb_flash_bridge.sv
module tb_apb_flash_bridge;
    localparam int AW  = 16;
    localparam int FAW = 12;
    localparam int CYC = 3;
    localparam logic [AW-1:0] CTRL  = 16'h0100;
    localparam logic [AW-1:0] FBASE = 16'h8000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0]  paddr = '0;
    logic [31:0]    pwdata = '0;
    logic [31:0]    prdata;
    logic           pready, pslverr;
    logic [FAW-1:0] fl_addr;
    logic [7:0]     fl_dout, fl_din;
    logic           fl_ce_n, fl_oe_n, fl_we_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem [256];

    int oe_clks, we_clks, ce_clks, oe_starts, we_starts;
    logic [7:0] oe_addrs [8];
    logic prev_oe_n = 1'b1, prev_we_n = 1'b1;

    always #5 clk = ~clk;

    apb_flash_bridge #(
        .AW(AW), .FAW(FAW), .STROBE_CYC(CYC), .CTRL_ADDR(CTRL), .FLASH_BASE(FBASE)
    ) dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    assign fl_din = (!fl_ce_n && !fl_oe_n) ? mem[fl_addr[7:0]] : 8'hFF;

    always @(posedge fl_we_n) begin
        if (!rst) mem[fl_addr[7:0]] <= fl_dout;
    end

    always @(negedge clk) begin
        if (!fl_oe_n) oe_clks++;
        if (!fl_we_n) we_clks++;
        if (!fl_ce_n) ce_clks++;
        if (!fl_oe_n && prev_oe_n) begin
            if (oe_starts < 8) oe_addrs[oe_starts] = fl_addr[7:0];
            oe_starts++;
        end
        if (!fl_we_n && prev_we_n) we_starts++;
        prev_oe_n = fl_oe_n;
        prev_we_n = fl_we_n;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        oe_clks = 0; we_clks = 0; ce_clks = 0; oe_starts = 0; we_starts = 0;
    endtask

    task automatic apb(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err, output int waits);
        @(negedge clk);
        clear_mon();
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        waits = 0;
        #1;
        while (!pready && waits < 200) begin
            @(negedge clk);
            #1;
            waits++;
        end
        if (waits >= 200) begin
            errors++;
            $display("FAIL R7 pready never rose: actual=0 expected=1");
        end
        rd  = prdata;
        err = pslverr;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] word_at(input int base);
        return {mem[base+3], mem[base+2], mem[base+1], mem[base]};
    endfunction

    task automatic t_reset();
        logic [31:0] rd; logic err; int w;
        check("R1", "ce_n after reset", {31'b0, fl_ce_n}, 32'd1);
        check("R1", "oe_n after reset", {31'b0, fl_oe_n}, 32'd1);
        check("R1", "we_n after reset", {31'b0, fl_we_n}, 32'd1);
        apb(1'b0, CTRL, 0, rd, err, w);
        check("R1", "mode after reset", rd, 32'd0);
        check("R2", "ctrl read waits", w, 0);
    endtask

    task automatic t_word_read();
        logic [31:0] rd; logic err; int w;
        apb(1'b0, FBASE + 16'h0010, 0, rd, err, w);
        check("R4", "word read data", rd, word_at(16));
        check("R4", "read strobe count", oe_starts, 4);
        for (int i = 0; i < 4; i++)
            check("R4", "burst address order", {24'b0, oe_addrs[i]}, 32'(16 + i));
        check("R6", "oe low clocks", oe_clks, 4 * CYC);
        check("R6", "ce matches strobes", ce_clks, 4 * CYC);
        check("R7", "word read waits", w, 4 * CYC + 4);
        check("R8", "no error on flash", {31'b0, err}, 0);
    endtask

    task automatic t_unaligned();
        logic [31:0] rd; logic err; int w;
        apb(1'b0, FBASE + 16'h0022, 0, rd, err, w);
        check("R10", "unaligned word data", rd, word_at(32));
        check("R10", "unaligned first addr", {24'b0, oe_addrs[0]}, 32'd32);
    endtask

    task automatic t_write();
        logic [31:0] rd; logic err; int w;
        apb(1'b1, FBASE + 16'h0035, 32'hDEADBE5A, rd, err, w);
        check("R3", "flash byte written", {24'b0, mem[8'h35]}, 32'h5A);
        check("R3", "neighbour untouched", {24'b0, mem[8'h34]}, 32'(8'(8'h34 * 29 + 8'h11)));
        check("R3", "write strobe count", we_starts, 1);
        check("R3", "no read strobe", oe_starts, 0);
        check("R3", "write pslverr", {31'b0, err}, 0);
        check("R6", "we low clocks", we_clks, CYC);
        check("R7", "write waits", w, CYC + 1);
    endtask

    task automatic t_mode();
        logic [31:0] rd; logic err; int w;
        apb(1'b1, CTRL, 32'hFFFF_FFFF, rd, err, w);
        check("R2", "ctrl write waits", w, 0);
        apb(1'b0, CTRL, 0, rd, err, w);
        check("R2", "mode readback", rd, 32'd1);
    endtask

    task automatic t_byte_read();
        logic [31:0] rd; logic err; int w;
        apb(1'b0, FBASE + 16'h0035, 0, rd, err, w);
        check("R5", "byte read data", rd, 32'h0000_005A);
        check("R5", "byte read strobes", oe_starts, 1);
        check("R5", "byte read addr", {24'b0, oe_addrs[0]}, 32'h35);
        check("R7", "byte read waits", w, CYC + 1);
    endtask

    task automatic t_error();
        logic [31:0] rd; logic err; int w;
        apb(1'b1, 16'h9000, 32'h0, rd, err, w);
        check("R8", "err write pslverr", {31'b0, err}, 1);
        check("R8", "err write waits", w, 0);
        check("R8", "err write no strobe", ce_clks, 0);
        apb(1'b1, CTRL + 16'h0004, 32'h0, rd, err, w);
        check("R8", "err near ctrl pslverr", {31'b0, err}, 1);
        apb(1'b0, 16'h0104, 0, rd, err, w);
        check("R8", "err read data", rd, 0);
        check("R8", "err read pslverr", {31'b0, err}, 1);
        apb(1'b0, CTRL, 0, rd, err, w);
        check("R8", "mode kept after err", rd, 32'd1);
    endtask

    task automatic t_mode_back();
        logic [31:0] rd; logic err; int w;
        apb(1'b1, CTRL, 32'h0, rd, err, w);
        apb(1'b0, FBASE + 16'h0034, 0, rd, err, w);
        check("R9", "new mode applies to next read", rd, word_at(52));
        check("R9", "strobes after mode change", oe_starts, 4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 8'h11);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word_read();
        t_unaligned();
        t_write();
        t_mode();
        t_byte_read();
        t_error();
        t_mode_back();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule